// File: doc/BRIEF.md
# Multi-Channel CRC-32 Context Engine

This block checks a 32-bit cyclic redundancy code on packets whose cells arrive interleaved across up to 128 virtual channels. Bytes stream in one per accepted transfer. Each transfer carries a channel number and three flags: start of cell, end of cell and end of packet. The engine keeps one partial remainder for each channel in a small context store. It fetches the channel's remainder when a cell begins and updates it byte by byte. It writes the remainder back once the cell's last byte has gone through, so a packet's cells may be spread among cells of other channels.

The register update is the reflected byte-wise form. The new remainder is the old remainder shifted right by eight bits, XORed with a table word. The table word is selected by the low remainder byte XORed with the data byte, and the 256-word table is generated from polynomial 0xEDB88320. The first cell of a packet always starts from 0xFFFFFFFF. When the last cell of a packet ends, the final register is compared with the fixed residue 0xDEBB20E3 and a one-cycle status pulse reports good or bad along with the channel. The stored context is split into two 16-bit halves that are always written and read together.

Top module: `crc_ctx_engine`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `in_ready_o` and `stat_valid_o` are low.
- R2: A packet whose trailing four bytes hold the complement of the running remainder, least significant byte first, produces `stat_good_o` = 1. The remainder is computed with preset 0xFFFFFFFF, reflected polynomial 0xEDB88320, one byte per step.
- R3: A packet with any corrupted byte produces `stat_good_o` = 0.
- R4: Cells of different channels may be interleaved, and each channel's remainder is unaffected by the other channels' bytes.
- R5: The first cell of a packet starts from 0xFFFFFFFF whatever the store holds for that channel. This covers a channel never used since reset and a channel whose previous packet ended bad.
- R6: When a start-of-cell byte is presented while no cell is active, `in_ready_o` stays low for exactly one cycle (the context load) and the byte is accepted in the next cycle.
- R7: `stat_valid_o` is high for exactly the one cycle after the edge that accepts an end-of-cell byte flagged end-of-packet, with `stat_chan_o` equal to that cell's channel. It stays low after cells that do not end a packet.
- R8: The cycle after an end-of-cell byte is the write-back cycle. `in_ready_o` is low in it, and a start-of-cell byte presented in it is loaded there, so the next cell's first byte is accepted one cycle later.
- R9: When a cell of the same channel follows directly in the write-back cycle, the remainder just written is forwarded, and the packet still checks good.
- R10: When the forwarded cell follows an end-of-packet on the same channel, it starts from 0xFFFFFFFF instead of the forwarded value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Payload byte valid |
| in_ready_o | output | 1 | Engine accepts the byte this cycle |
| in_data_i | input | 8 | Payload byte |
| in_chan_i | input | 7 | Channel number, sampled with the start-of-cell byte |
| in_soc_i | input | 1 | Byte is the first of a cell |
| in_eoc_i | input | 1 | Byte is the last of a cell |
| in_eop_i | input | 1 | Cell ends a packet (meaningful with in_eoc_i) |
| stat_valid_o | output | 1 | One-cycle packet result strobe |
| stat_good_o | output | 1 | Final remainder matched the residue |
| stat_chan_o | output | 7 | Channel of the reported packet |

## Verification
A start-of-cell byte presented in an idle or write-back cycle is accepted two rising edges later. Every later byte of the cell is accepted on the first edge at which it is presented. The status strobe is due in the cycle after the edge that accepts the end-of-packet byte. The bench drives one nanosecond after each falling edge and reads `in_ready_o` and the status outputs at that point. It counts how many cycles each first byte waits and checks the status in the exact cycle it is due, then checks that it has gone low one cycle later. The expected good or bad result comes from a bit-serial remainder model in the bench.

// File: rtl/crc_ctx_pkg.sv
package crc_ctx_pkg;
  localparam int unsigned CRC_W = 32;
  localparam logic [31:0] CRC_POLY    = 32'hEDB88320;
  localparam logic [31:0] CRC_PRESET  = 32'hFFFFFFFF;
  localparam logic [31:0] CRC_RESIDUE = 32'hDEBB20E3;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_WB   = 2'd2
  } eng_state_e;

  // table word for one index, computed rather than stored
  function automatic logic [31:0] crc_tab_word(input logic [7:0] idx);
    logic [31:0] r;
    r = {24'h0, idx};
    for (int b = 0; b < 8; b++) begin
      r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
    end
    return r;
  endfunction
endpackage

// File: rtl/crc_byte_step.sv
module crc_byte_step
  import crc_ctx_pkg::*;
(
  input  logic [CRC_W-1:0] crc_i,
  input  logic [7:0]       data_i,
  output logic [CRC_W-1:0] crc_o
);
  logic [7:0] tab_idx;

  assign tab_idx = crc_i[7:0] ^ data_i;
  assign crc_o   = (crc_i >> 8) ^ crc_tab_word(tab_idx);
endmodule

// File: rtl/ctx_store.sv
module ctx_store
  import crc_ctx_pkg::*;
#(
  parameter int unsigned CHAN_W = 7,
  parameter int unsigned WORD_W = 32,
  parameter int unsigned PART_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CHAN_W-1:0] rd_addr_i,
  output logic [WORD_W-1:0] rd_word_o,
  input  logic              wr_en_i,
  input  logic [CHAN_W-1:0] wr_addr_i,
  input  logic [WORD_W-1:0] wr_word_i,
  input  logic              wr_close_i
);
  localparam int unsigned DEPTH = 1 << CHAN_W;
  localparam int unsigned PARTS = WORD_W / PART_W;

  // open bit marks a packet in progress; closed entries read as preset
  logic [DEPTH-1:0]  open_q;
  logic [WORD_W-1:0] raw_word;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= '0;
    end else if (wr_en_i) begin
      open_q[wr_addr_i] <= !wr_close_i;
    end
  end

  for (genvar g = 0; g < PARTS; g++) begin : g_part
    logic [PART_W-1:0] bank [DEPTH];

    always_ff @(posedge clk_i) begin
      if (wr_en_i) bank[wr_addr_i] <= wr_word_i[g*PART_W +: PART_W];
    end

    assign raw_word[g*PART_W +: PART_W] = bank[rd_addr_i];
  end

  assign rd_word_o = open_q[rd_addr_i] ? raw_word : WORD_W'(CRC_PRESET);

  AST_WB_OPENS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_close_i) |=> open_q[$past(wr_addr_i)]) else $error("open"); // R4
  AST_EOP_CLOSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_close_i) |=> !open_q[$past(wr_addr_i)]) else $error("close"); // R5
endmodule

// File: rtl/crc_ctx_engine.sv
module crc_ctx_engine
  import crc_ctx_pkg::*;
#(
  parameter int unsigned CHAN_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [7:0]        in_data_i,
  input  logic [CHAN_W-1:0] in_chan_i,
  input  logic              in_soc_i,
  input  logic              in_eoc_i,
  input  logic              in_eop_i,
  output logic              stat_valid_o,
  output logic              stat_good_o,
  output logic [CHAN_W-1:0] stat_chan_o
);
  eng_state_e        state_q;
  logic [CHAN_W-1:0] chan_q;
  logic [CRC_W-1:0]  crc_q, crc_nxt, rd_word, load_word;
  logic              eop_q;
  logic              stat_valid_q, stat_good_q;
  logic [CHAN_W-1:0] stat_chan_q;
  logic              load_req, fwd_hit, acc, wr_en;

  assign in_ready_o = (state_q == ST_RUN);
  assign acc        = in_valid_i && in_ready_o;
  assign load_req   = in_valid_i && in_soc_i && (state_q != ST_RUN);
  assign wr_en      = (state_q == ST_WB);

  // same channel directly after write-back: bypass the store
  assign fwd_hit   = (state_q == ST_WB) && (in_chan_i == chan_q);
  assign load_word = fwd_hit ? (eop_q ? CRC_PRESET : crc_q) : rd_word;

  crc_byte_step u_step (
    .crc_i  (crc_q),
    .data_i (in_data_i),
    .crc_o  (crc_nxt)
  );

  ctx_store #(
    .CHAN_W (CHAN_W),
    .WORD_W (CRC_W),
    .PART_W (CRC_W / 2)
  ) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_addr_i  (in_chan_i),
    .rd_word_o  (rd_word),
    .wr_en_i    (wr_en),
    .wr_addr_i  (chan_q),
    .wr_word_i  (crc_q),
    .wr_close_i (eop_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      chan_q       <= '0;
      crc_q        <= CRC_PRESET;
      eop_q        <= 1'b0;
      stat_valid_q <= 1'b0;
      stat_good_q  <= 1'b0;
      stat_chan_q  <= '0;
    end else begin
      stat_valid_q <= 1'b0;
      case (state_q)
        ST_RUN: begin
          if (acc) begin
            crc_q <= crc_nxt;
            if (in_eoc_i) begin
              state_q      <= ST_WB;
              eop_q        <= in_eop_i;
              stat_valid_q <= in_eop_i;
              stat_good_q  <= (crc_nxt == CRC_RESIDUE);
              stat_chan_q  <= chan_q;
            end
          end
        end
        default: begin
          if (load_req) begin
            chan_q  <= in_chan_i;
            crc_q   <= load_word;
            state_q <= ST_RUN;
          end else begin
            state_q <= ST_IDLE;
          end
        end
      endcase
    end
  end

  assign stat_valid_o = stat_valid_q;
  assign stat_good_o  = stat_good_q;
  assign stat_chan_o  = stat_chan_q;

  AST_LOAD_THEN_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_req |=> in_ready_o) else $error("load"); // R6
  AST_STAT_AFTER_EOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_valid_o |-> $past(acc && in_eoc_i && in_eop_i)) else $error("stat"); // R7
  AST_WB_AFTER_EOC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && in_eoc_i) |=> (wr_en && !in_ready_o)) else $error("wb"); // R8
  AST_STAT_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_valid_o |=> !stat_valid_o) else $error("pulse"); // R7
endmodule

// File: tb/crc_ctx_engine_test.sv
module crc_ctx_engine_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       in_valid_i = 1'b0;
  logic       in_ready_o;
  logic [7:0] in_data_i = '0;
  logic [6:0] in_chan_i = '0;
  logic       in_soc_i = 1'b0, in_eoc_i = 1'b0, in_eop_i = 1'b0;
  logic       stat_valid_o, stat_good_o;
  logic [6:0] stat_chan_o;

  int total = 0;
  int bad = 0;
  logic [7:0] pkt [4][64];
  int plen [4];

  always #5 clk_i = ~clk_i;

  crc_ctx_engine uut (.*);

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] m_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int b = 0; b < 8; b++) begin
      r = ((r[0] ^ d[b]) != 1'b0) ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    end
    return r;
  endfunction

  task automatic build(input int s, input int n, input int seed);
    logic [31:0] c;
    c = 32'hFFFFFFFF;
    for (int i = 0; i < n; i++) begin
      pkt[s][i] = 8'(seed * 31 + i * 17 + (i >> 2));
      c = m_step(c, pkt[s][i]);
    end
    c = ~c;
    for (int k = 0; k < 4; k++) pkt[s][n + k] = c[8*k +: 8];
    plen[s] = n + 4;
  endtask

  // called 1 ns after a falling edge; returns at the same phase
  task automatic send_cell(input int s, input int first, input int n, input logic [6:0] ch,
                           input bit eop, input bit exp_good, input string req);
    int waits = 0;
    for (int i = 0; i < n; i++) begin
      in_valid_i = 1'b1;
      in_soc_i   = (i == 0);
      in_eoc_i   = (i == n - 1);
      in_eop_i   = eop && (i == n - 1);
      in_data_i  = pkt[s][first + i];
      in_chan_i  = (i == 0) ? ch : ~ch;
      while (!in_ready_o) begin
        if (i == 0) waits++;
        @(negedge clk_i); #1;
      end
      @(negedge clk_i); #1;
    end
    in_valid_i = 1'b0; in_soc_i = 1'b0; in_eoc_i = 1'b0; in_eop_i = 1'b0;
    check(waits == 1, {"R6 R8 load wait ", req}, waits, 1);
    check(stat_valid_o == eop, {"R7 strobe ", req}, stat_valid_o, eop);
    if (eop) begin
      check(stat_good_o == exp_good, {"status ", req}, stat_good_o, exp_good);
      check(stat_chan_o == ch, "R7 channel", stat_chan_o, ch);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk_i); #1; end
  endtask

  task automatic t_reset;
    #1;
    check(in_ready_o == 1'b0, "R1 ready in reset", in_ready_o, 0);
    check(stat_valid_o == 1'b0, "R1 status in reset", stat_valid_o, 0);
    @(negedge clk_i); rst_ni = 1'b1; #1;
    @(negedge clk_i); #1;
    check(in_ready_o == 1'b0, "R1 ready after reset", in_ready_o, 0);
    check(stat_valid_o == 1'b0, "R1 status after reset", stat_valid_o, 0);
  endtask

  task automatic t_single;
    build(0, 12, 1);
    send_cell(0, 0, plen[0], 7'd3, 1'b1, 1'b1, "R2 single cell");
    idle(1);
    check(stat_valid_o == 1'b0, "R7 pulse ends", stat_valid_o, 0);
  endtask

  task automatic t_bad;
    build(1, 20, 2);
    pkt[1][2] = pkt[1][2] ^ 8'h10;
    send_cell(1, 0, plen[1], 7'd4, 1'b1, 1'b0, "R3 corrupt");
    idle(2);
    build(1, 9, 3);
    send_cell(1, 0, plen[1], 7'd4, 1'b1, 1'b1, "R5 after bad");
    idle(1);
  endtask

  task automatic t_interleave;
    build(0, 12, 5);   // 16 bytes
    build(2, 16, 6);   // 20 bytes
    send_cell(0, 0, 6, 7'd5, 1'b0, 1'b0, "R4 a1");
    send_cell(2, 0, 8, 7'd9, 1'b0, 1'b0, "R4 b1");
    send_cell(0, 6, 6, 7'd5, 1'b0, 1'b0, "R4 a2");
    send_cell(2, 8, 8, 7'd9, 1'b0, 1'b0, "R4 b2");
    send_cell(0, 12, 4, 7'd5, 1'b1, 1'b1, "R4 a end");
    send_cell(2, 16, 4, 7'd9, 1'b1, 1'b1, "R4 b end");
    idle(2);
  endtask

  task automatic t_forward;
    build(3, 12, 8);
    send_cell(3, 0, 8, 7'd7, 1'b0, 1'b0, "R9 first");
    send_cell(3, 8, 8, 7'd7, 1'b1, 1'b1, "R9 forwarded");
    idle(1);
  endtask

  task automatic t_after_eop;
    build(1, 10, 9);
    pkt[1][0] = ~pkt[1][0];
    send_cell(1, 0, plen[1], 7'd7, 1'b1, 1'b0, "R3 bad before");
    build(3, 6, 10);
    send_cell(3, 0, plen[3], 7'd7, 1'b1, 1'b1, "R10 preset after eop");
    idle(1);
  endtask

  task automatic t_top_chan;
    build(0, 30, 11);
    send_cell(0, 0, 17, 7'd127, 1'b0, 1'b0, "R5 fresh 127 a");
    send_cell(0, 17, 17, 7'd127, 1'b1, 1'b1, "R5 fresh 127 b");
    idle(1);
  endtask

  initial begin
    #2_000_000;
    check(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_single();
    t_bad();
    t_interleave();
    t_forward();
    t_after_eop();
    t_top_chan();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule